// File: doc/BRIEF.md
# Unlock-Gated Serial Configuration Loader

This block takes configuration words from a slow two-wire link. One wire is a serial clock and the other is a serial data line. Both wires are sampled by a fast system clock. The block ignores the link until a preamble unlocks it. It then reads one framed word in which every bit is sent twice across the two serial clock edges. When a valid stop arrives, it hands a 21-bit data value and a 3-bit register address to a downstream register file over a valid/ready port.

The block raises a sticky, active-low error flag for malformed frames. A quiet-line watchdog, counted in system clock cycles, abandons a half-received transfer. While the power-down input is high, the link is ignored.

Back-pressure on the write port works as follows. Once `wr_valid_o` rises, it stays high with `wr_addr_o` and `wr_data_o` held stable until a cycle in which `wr_ready_i` is high. A frame that completes while a write is still pending is refused and treated as an error. `wr_ready_i` has no effect on anything else. `pwr_dn_i` is expected to be synchronous to `clk`.

Top module: `serial_cfg_loader`

## Requirements
- R1: The receiver unlocks only after at least 5 serial-clock rising edges with data high, followed directly by a rising edge with data low. A shorter run followed by a low-data rise leaves it locked, and that low rise restarts the count.
- R2: Once unlocked, each bit is a pair: the data level at a falling edge, then the level at the next rising edge. A payload bit is the rising-edge level and requires the falling-edge level to be its complement. An equal pair inside the payload is an error.
- R3: A frame is a start pair (low at both edges), then 24 payload bits, then a stop pair. The first payload bit is data bit 20 and the 21st is data bit 0. The last three bits are the address, most significant first.
- R4: A stop pair (high at both edges) after exactly 24 payload bits produces one write beat with the received data and address. After reset `wr_valid_o` is 0.
- R5: Only addresses 0, 1, 2, 3, 4 and 6 produce a write beat. Addresses 5 and 7 are dropped silently, with no error.
- R6: When no transition occurs on either serial line for the watchdog interval while a preamble or frame is in progress, the partial state is discarded and the receiver relocks without raising an error.
- R7: `err_n_o` is 1 after reset. It goes to 0 on any framing fault and stays 0 until the next successful unlock.
- R8: A start pair that is not low-low is an error.
- R9: A stop slot whose pair is low-low is an error.
- R10: A stop slot that carries a complementary pair (an extra data bit after the word is full) is an error, and no write is made.
- R11: While `pwr_dn_i` is 1, link activity cannot unlock the receiver or produce a write.
- R12: After a load the receiver is locked again, so a further frame without a new preamble produces no write.
- R13: `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold steady while `wr_ready_i` is 0. A frame completing during that time is refused with an error, and the pending beat is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial link clock line (asynchronous) |
| ser_dat_i | input | 1 | Serial link data line (asynchronous) |
| pwr_dn_i | input | 1 | High blocks programming |
| wr_valid_o | output | 1 | Write beat available |
| wr_ready_i | input | 1 | Downstream accepts the beat |
| wr_addr_o | output | 3 | Target register address |
| wr_data_o | output | 21 | Register data |
| err_n_o | output | 1 | Low after a framing fault |

## Verification
Every one of the eight addresses is sent with all-zero, all-one, alternating and mixed data. This separates the accepted addresses from the silently dropped ones and exposes a stuck data bit. A walking single one across all 21 data positions, spread over the legal addresses, pins down the bit order and the data/address split. Each fault is driven in isolation: a bad start pair, an equal pair mid-word, a stop sent early, a low-low stop, and an extra bit after the word. Each must yield a low error flag and no write, and a following unlock must clear the flag. Short preambles, line silence in the middle of a preamble or frame, power-down, a frame sent without a preamble and a frame sent during a stalled write separate the lock, watchdog and back-pressure paths.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic {
    ST_LOCKED = 1'b0,
    ST_RECV   = 1'b1
  } rx_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic cur_o,
  output logic prev_o
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      cur_o  <= RST_VAL;
      prev_o <= RST_VAL;
    end else begin
      meta_q <= in_i;
      cur_o  <= meta_q;
      prev_o <= cur_o;
    end
  end
endmodule

// File: rtl/slp_watchdog.sv
module slp_watchdog #(
  parameter int LIMIT = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic arm_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (kick_i || !arm_i) begin
        cnt_q <= '0;
      end else if (cnt_q != CW'(LIMIT)) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(LIMIT - 1)) expire_o <= 1'b1;
      end
    end
  end

  // R6: a line transition always holds off expiry on the next cycle
  a_r6_kick_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !expire_o);
  // R6: expiry is a single pulse per quiet stretch
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
endmodule

// File: rtl/slp_frame_rx.sv
module slp_frame_rx
  import slp_pkg::*;
#(
  parameter int PAY_W      = 24,
  parameter int UNLOCK_MIN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             dat_i,
  input  logic             pd_i,
  input  logic             timeout_i,
  input  logic             sink_busy_i,
  output logic             busy_o,
  output logic             load_o,
  output logic [PAY_W-1:0] word_o,
  output logic             err_o
);
  localparam int SLOT_W = $clog2(PAY_W + 2);
  localparam int PRE_W  = $clog2(UNLOCK_MIN + 1);
  localparam logic [SLOT_W-1:0] STOP_SLOT = SLOT_W'(PAY_W + 1);
  localparam logic [PRE_W-1:0]  PRE_FULL  = PRE_W'(UNLOCK_MIN);

  rx_state_e         st_q;
  logic [PRE_W-1:0]  pre_q;
  logic [SLOT_W-1:0] slot_q;
  logic              fall_smp_q;

  logic is_start, is_stop, start_ok, pair_ok, stop_ok, rx_fail, rx_load;

  always_comb begin
    is_start = (slot_q == '0);
    is_stop  = (slot_q == STOP_SLOT);
    start_ok = !fall_smp_q && !dat_i;
    pair_ok  = (fall_smp_q != dat_i);
    stop_ok  = fall_smp_q && dat_i && !sink_busy_i;
    rx_fail  = rise_i && (is_start ? !start_ok : (is_stop ? !stop_ok : !pair_ok));
    rx_load  = rise_i && is_stop && stop_ok;
  end

  assign busy_o = (st_q == ST_RECV) || (pre_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_LOCKED;
      pre_q      <= '0;
      slot_q     <= '0;
      fall_smp_q <= 1'b0;
      word_o     <= '0;
      load_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (pd_i || timeout_i) begin
        st_q  <= ST_LOCKED;
        pre_q <= '0;
      end else if (st_q == ST_LOCKED) begin
        if (rise_i) begin
          if (dat_i) begin
            if (pre_q != PRE_FULL) pre_q <= pre_q + 1'b1;
          end else begin
            if (pre_q == PRE_FULL) begin
              st_q   <= ST_RECV;
              slot_q <= '0;
              err_o  <= 1'b0;
            end
            pre_q <= '0;
          end
        end
      end else begin
        if (fall_i) fall_smp_q <= dat_i;
        if (rx_fail) begin
          err_o <= 1'b1;
          st_q  <= ST_LOCKED;
          pre_q <= '0;
        end else if (rx_load) begin
          load_o <= 1'b1;
          st_q   <= ST_LOCKED;
          pre_q  <= '0;
        end else if (rise_i) begin
          if (!is_start) word_o <= {word_o[PAY_W-2:0], dat_i};
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  // R1: entering the receive state needs a full preamble count just before
  a_r1_unlock_needs_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_RECV) |-> ($past(pre_q) == PRE_FULL));
  // R7: the error flag is only cleared by entering the receive state
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> (st_q == ST_RECV));
  // R12: a load leaves the receiver locked
  a_r12_relock_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (st_q == ST_LOCKED));
  // R11: power-down forces the lock and blocks a load
  a_r11_pd_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> (st_q == ST_LOCKED) && !load_o);
  // R6: watchdog expiry relocks the receiver
  a_r6_timeout_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_i |=> (st_q == ST_LOCKED) && (pre_q == '0));
endmodule

// File: rtl/slp_wr_port.sv
module slp_wr_port #(
  parameter int DATA_W = 21,
  parameter int ADDR_W = 3,
  parameter logic [(1<<ADDR_W)-1:0] ADDR_MASK = 8'h5F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [DATA_W+ADDR_W-1:0] word_i,
  output logic                     valid_o,
  input  logic                     ready_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [DATA_W-1:0]        data_o
);
  logic [ADDR_W-1:0] in_addr;
  assign in_addr = word_i[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (load_i && ADDR_MASK[in_addr] && !valid_o) begin
        valid_o <= 1'b1;
        addr_o  <= in_addr;
        data_o  <= word_i[DATA_W+ADDR_W-1:ADDR_W];
      end
    end
  end

  // R13: a stalled beat keeps its contents
  a_r13_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(data_o));
  // R5: only mapped addresses ever leave the block
  a_r5_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ADDR_MASK[addr_o]);
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int DATA_W      = 21,
  parameter int ADDR_W      = 3,
  parameter int UNLOCK_MIN  = 5,
  parameter int WDOG_CYCLES = 200000,
  parameter logic [(1<<ADDR_W)-1:0] ADDR_MASK = 8'h5F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              pwr_dn_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              err_n_o
);
  localparam int PAY_W   = DATA_W + ADDR_W;
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw, cur, prev;
  assign raw = {ser_dat_i, ser_clk_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    slp_sync #(.RST_VAL(1'b0)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .in_i   (raw[g]),
      .cur_o  (cur[g]),
      .prev_o (prev[g])
    );
  end

  logic sclk_rise, sclk_fall, line_kick, rx_busy, wd_expire, rx_load, rx_err;
  logic [PAY_W-1:0] rx_word;

  assign sclk_rise = cur[0] & ~prev[0];
  assign sclk_fall = ~cur[0] & prev[0];
  assign line_kick = |(cur ^ prev);

  slp_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick_i   (line_kick),
    .arm_i    (rx_busy),
    .expire_o (wd_expire)
  );

  slp_frame_rx #(.PAY_W(PAY_W), .UNLOCK_MIN(UNLOCK_MIN)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (sclk_rise),
    .fall_i      (sclk_fall),
    .dat_i       (cur[1]),
    .pd_i        (pwr_dn_i),
    .timeout_i   (wd_expire),
    .sink_busy_i (wr_valid_o),
    .busy_o      (rx_busy),
    .load_o      (rx_load),
    .word_o      (rx_word),
    .err_o       (rx_err)
  );

  slp_wr_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_MASK(ADDR_MASK)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (rx_load),
    .word_i  (rx_word),
    .valid_o (wr_valid_o),
    .ready_i (wr_ready_i),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o)
  );

  assign err_n_o = ~rx_err;

  // R7: the error output can only fall on a serial clock rising edge event
  a_r7_err_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n_o) |-> $past(sclk_rise));
endmodule

// File: tb/serial_cfg_loader_bench.sv
`timescale 1ns/1ps
module serial_cfg_loader_bench;
  localparam int H    = 8;
  localparam int WDOG = 64;

  logic clk = 1'b0;
  logic rst_n, sclk, sdat, pd, ready;
  logic wr_valid, err_n;
  logic [2:0]  wr_addr;
  logic [20:0] wr_data;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  serial_cfg_loader #(.WDOG_CYCLES(WDOG)) u_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .pwr_dn_i(pd), .wr_valid_o(wr_valid), .wr_ready_i(ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .err_n_o(err_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pair(input logic f, input logic r);
    sdat = f; cyc(H); sclk = 1'b0; cyc(H);
    sdat = r; cyc(H); sclk = 1'b1; cyc(H);
  endtask

  task automatic unlock();
    repeat (5) pair(1'b1, 1'b1);
    pair(1'b1, 1'b0);
  endtask

  task automatic payload(input logic [20:0] d, input logic [2:0] a);
    for (int i = 20; i >= 0; i--) pair(~d[i], d[i]);
    for (int i = 2; i >= 0; i--) pair(~a[i], a[i]);
  endtask

  task automatic frame(input logic [20:0] d, input logic [2:0] a);
    pair(1'b0, 1'b0);
    payload(d, a);
    pair(1'b1, 1'b1);
  endtask

  task automatic consume();
    ready = 1'b1; cyc(1); ready = 1'b0; cyc(1);
    chk("R13 beat consumed", 32'(wr_valid), 32'd0);
  endtask

  task automatic send_and_check(input string tag, input logic [20:0] d, input logic [2:0] a);
    logic exp_ok;
    exp_ok = (a != 3'd5) && (a != 3'd7);
    unlock();
    frame(d, a);
    chk({tag, " valid"}, 32'(wr_valid), 32'(exp_ok));
    if (exp_ok) begin
      chk({tag, " addr"}, 32'(wr_addr), 32'(a));
      chk({tag, " data"}, 32'(wr_data), 32'(d));
      consume();
    end
    chk({tag, " err_n"}, 32'(err_n), 32'd1);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] legal [6];
    logic [20:0] d;
    legal = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
    sclk = 0; sdat = 0; pd = 0; ready = 0; rst_n = 0;
    cyc(5); rst_n = 1; cyc(4);
    chk("R4 reset valid", 32'(wr_valid), 32'd0);
    chk("R7 reset err_n", 32'(err_n), 32'd1);

    // R5 / R4: every address with several data patterns
    for (int a = 0; a < 8; a++) begin
      for (int p = 0; p < 4; p++) begin
        case (p)
          0: d = 21'h0;
          1: d = 21'h1FFFFF;
          2: d = 21'h155555;
          default: d = 21'(((a * 7 + 1) * 32'h1357) ^ 32'h0F0F0);
        endcase
        send_and_check("R5 addr sweep", d, 3'(a));
      end
    end

    // R3: walking one across the data field
    for (int i = 0; i < 21; i++) send_and_check("R3 walking one", 21'(1) << i, legal[i % 6]);

    // R12: no write without a fresh preamble
    send_and_check("R12 first", 21'h12345, 3'd1);
    frame(21'h0, 3'd0);
    chk("R12 no relock write", 32'(wr_valid), 32'd0);

    // R8: bad start pair
    unlock(); pair(1'b1, 1'b1);
    chk("R8 bad start err_n", 32'(err_n), 32'd0);
    chk("R8 bad start valid", 32'(wr_valid), 32'd0);
    unlock();
    chk("R7 cleared by unlock", 32'(err_n), 32'd1);
    frame(21'h0ABCD, 3'd2);
    chk("R7 recovery valid", 32'(wr_valid), 32'd1);
    consume();

    // R2: equal pair inside the payload
    unlock(); pair(1'b0, 1'b0);
    repeat (4) pair(1'b1, 1'b0);
    pair(1'b0, 1'b0);
    chk("R2 bad pair err_n", 32'(err_n), 32'd0);
    unlock();
    chk("R7 clear after R2", 32'(err_n), 32'd1);

    // R2: stop sent after only 10 bits
    pair(1'b0, 1'b0);
    repeat (10) pair(1'b0, 1'b1);
    pair(1'b1, 1'b1);
    chk("R2 short word err_n", 32'(err_n), 32'd0);
    chk("R2 short word valid", 32'(wr_valid), 32'd0);

    // R9: low-low stop
    unlock(); pair(1'b0, 1'b0); payload(21'h1F00F, 3'd3); pair(1'b0, 1'b0);
    chk("R9 bad stop err_n", 32'(err_n), 32'd0);
    chk("R9 bad stop valid", 32'(wr_valid), 32'd0);

    // R10: extra bit after a full word
    unlock(); pair(1'b0, 1'b0); payload(21'h1F00F, 3'd3); pair(1'b1, 1'b0);
    chk("R10 overrun err_n", 32'(err_n), 32'd0);
    chk("R10 overrun valid", 32'(wr_valid), 32'd0);

    // R13: frame completing while a beat is stalled
    unlock(); frame(21'h0C0DE, 3'd3);
    chk("R13 first beat", 32'(wr_valid), 32'd1);
    unlock(); frame(21'h1BEEF, 3'd1);
    chk("R13 collision err_n", 32'(err_n), 32'd0);
    chk("R13 kept addr", 32'(wr_addr), 32'd3);
    chk("R13 kept data", 32'(wr_data), 32'h0C0DE);
    consume();

    // R11: power-down refuses programming
    pd = 1'b1;
    unlock(); frame(21'h00077, 3'd0);
    chk("R11 pd no write", 32'(wr_valid), 32'd0);
    pd = 1'b0;
    unlock();
    chk("R11 unlock after pd", 32'(err_n), 32'd1);
    frame(21'h00077, 3'd0);
    chk("R11 write after pd", 32'(wr_valid), 32'd1);
    consume();

    // R6: silence in the middle of a frame
    unlock(); pair(1'b0, 1'b0);
    repeat (5) pair(1'b1, 1'b0);
    cyc(WDOG + 40);
    repeat (16) pair(1'b1, 1'b0);
    payload(21'h0, 3'd0);
    pair(1'b1, 1'b1);
    chk("R6 mid-frame timeout valid", 32'(wr_valid), 32'd0);
    chk("R6 timeout no error", 32'(err_n), 32'd1);
    cyc(WDOG + 40);

    // R6: silence inside the preamble
    repeat (3) pair(1'b1, 1'b1);
    cyc(WDOG + 40);
    repeat (2) pair(1'b1, 1'b1);
    pair(1'b1, 1'b0);
    frame(21'h0, 3'd0);
    chk("R6 preamble timeout valid", 32'(wr_valid), 32'd0);
    cyc(WDOG + 40);

    // R1: only four high rises
    repeat (4) pair(1'b1, 1'b1);
    pair(1'b1, 1'b0);
    frame(21'h0, 3'd0);
    chk("R1 short preamble valid", 32'(wr_valid), 32'd0);
    cyc(WDOG + 40);
    send_and_check("R1 full preamble", 21'h1A5A5, 3'd4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule